// File: doc/BRIEF.md
# Flash unlock command sequencer

This block sits behind the write port of a byte-wide parallel NOR flash and turns the stream of command writes into requests for the program/erase engine. Each write strobe carries an address and a data byte, already latched. Most commands are accepted only after a two-write unlock handshake. Erase needs a second handshake before it is confirmed. A few single-write commands (reset, suspend and resume) need no handshake. A write that breaks a sequence drops the sequencer back to array reads.

The block also chooses what a read returns. It can select the array, a manufacturer identifier, a device identifier or the per-block protection flag. While the engine is working, the block filters writes according to which operation it last launched. It is used by tying the write strobe and bus latches to its inputs and the request pulses to the engine. The engine reports back through the busy and suspended inputs.

Top module: `flash_cmd_seq`

## Requirements
- R1: The unlock pair is data AAh at a key-A address, then data 55h at a key-B address. Only address bits 14..0 are compared: key A is 5555h and key B is 2AAAh. Higher address bits do not matter.
- R2: While the engine is idle, data F0h at any address resets the sequencer. It pulses reset_o and returns to array reads. This holds from any state except the program-data cycle, and needs no unlock.
- R3: After unlock, 90h at key A enters signature mode. For reads with address bit 6 low, rd_sel_o decodes {bit1,bit0}: 00 gives 1 (manufacturer, sig_byte_o = MFR_CODE); 01 gives 2 (device, sig_byte_o = DEV_CODE); 10 gives 3 (protection, sig_byte_o = 01h if prot_i[addr[18:16]] is set, else 00h). Any other combination gives 0 with sig_byte_o = 00h. Outside signature mode rd_sel_o is 0 (array) and sig_byte_o is 00h.
- R4: Any write accepted while the engine is idle leaves signature mode.
- R5: After unlock, A0h at any address arms program. The next write, whatever its value, pulses prog_req_o. prog_addr_o and prog_data_o show that write's address and data and hold them until the next program.
- R6: The sequence unlock, 80h at key A, unlock, 10h at key A pulses chip_erase_o.
- R7: The sequence unlock, 80h at key A, unlock, 30h at any address pulses blk_erase_o. blk_o is set to address bits 18..16 of that write.
- R8: A write that does not fit the current step returns the sequencer to idle without a pulse. B0h and 30h are ignored when the engine is idle and no erase is pending.
- R9: While busy_i is high after a program request, every write is ignored, F0h included.
- R10: While busy_i is high after a chip-erase request, only F0h is acted on, and it pulses reset_o.
- R11: While busy_i is high after a block-erase request and suspended_i is low: B0h pulses suspend_o, 30h pulses blk_erase_o with the new block, and F0h pulses reset_o. Any other write is ignored.
- R12: While suspended_i is high, 30h pulses resume_o and F0h pulses reset_o. Any other write is ignored.
- R13: Each request output is a one-cycle pulse, registered one clock after the write. A write produces at most one pulse. Back-to-back write cycles are each decoded.
- R14: After reset all pulses are low, reads select the array, and prog_addr_o, prog_data_o and blk_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | AW | Latched write address |
| data_i | input | 8 | Latched write data |
| busy_i | input | 1 | Engine is executing an operation |
| suspended_i | input | 1 | Engine holds a suspended block erase |
| rd_addr_i | input | AW | Current read address |
| prot_i | input | NBLK | Protection flag per block |
| rd_sel_o | output | 2 | Read source: 0 array, 1 manufacturer, 2 device, 3 protection |
| sig_byte_o | output | 8 | Identifier or protection byte for the selected source |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | AW | Program target address |
| prog_data_o | output | 8 | Program data byte |
| chip_erase_o | output | 1 | Chip-erase request pulse |
| blk_erase_o | output | 1 | Block-erase request pulse |
| blk_o | output | log2(NBLK) | Block index of the last block-erase request |
| suspend_o | output | 1 | Erase-suspend pulse |
| resume_o | output | 1 | Erase-resume pulse |
| reset_o | output | 1 | Reset-to-read-array pulse |

## Verification
The hardest case to reach is the filtering that depends on the engine. It requires a block erase that really was launched, then busy, then suspended, and it must be checked against writes that would be legal in other phases. The bench acts as the engine: it raises busy_i only after the request pulse it expects, and raises suspended_i only after a suspend pulse. Inside those windows it sends reset, suspend, resume and stray bytes. Broken sequences are tested at every step of the six-write erase, and with keys whose upper address bits are set.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3
  } seq_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_CHIP, OP_BLK} op_kind_e;

  typedef enum logic [1:0] {RS_ARRAY, RS_MFR, RS_DEV, RS_PROT} rd_sel_e;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_SIG    = 8'h90;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_BLOCK  = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
endpackage

// File: rtl/fcs_addr_match.sv
module fcs_addr_match #(
  parameter int unsigned        KW    = 15,
  parameter logic [KW-1:0]      KEY_A = 15'h5555,
  parameter logic [KW-1:0]      KEY_B = 15'h2AAA
) (
  input  logic [KW-1:0] key_bits_i,
  output logic          at_a_o,
  output logic          at_b_o
);
  assign at_a_o = (key_bits_i == KEY_A);
  assign at_b_o = (key_bits_i == KEY_B);
endmodule

// File: rtl/fcs_busy_filter.sv
module fcs_busy_filter
  import fcs_pkg::*;
(
  input  logic     wr_i,
  input  logic [7:0] data_i,
  input  logic     busy_i,
  input  logic     susp_i,
  input  op_kind_e kind_i,
  output logic     active_o,
  output logic     rst_o,
  output logic     sus_o,
  output logic     res_o,
  output logic     add_o
);
  assign active_o = busy_i | susp_i;

  always_comb begin
    rst_o = 1'b0;
    sus_o = 1'b0;
    res_o = 1'b0;
    add_o = 1'b0;
    if (wr_i) begin
      if (susp_i) begin
        res_o = (data_i == CMD_RESUME);
        rst_o = (data_i == CMD_RESET);
      end else if (busy_i) begin
        unique case (kind_i)
          OP_CHIP: rst_o = (data_i == CMD_RESET);
          OP_BLK: begin
            sus_o = (data_i == CMD_SUSP);
            add_o = (data_i == CMD_BLOCK);
            rst_o = (data_i == CMD_RESET);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fcs_unlock_fsm.sv
module fcs_unlock_fsm
  import fcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  input  logic       at_a_i,
  input  logic       at_b_i,
  output logic       ev_prog_o,
  output logic       ev_chip_o,
  output logic       ev_blk_o,
  output logic       ev_rst_o,
  output logic       sig_o
);
  seq_state_e state_q, state_d;
  logic       sig_q, sig_d;

  always_comb begin
    state_d   = state_q;
    sig_d     = 1'b0;
    ev_prog_o = 1'b0;
    ev_chip_o = 1'b0;
    ev_blk_o  = 1'b0;
    ev_rst_o  = 1'b0;
    if (wr_i) begin
      state_d = ST_IDLE;
      if (state_q == ST_PROG) begin
        ev_prog_o = 1'b1;
      end else if (data_i == CMD_RESET) begin
        ev_rst_o = 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (data_i == CMD_KEY_A && at_a_i) state_d = ST_UNL1;
          ST_UNL1: if (data_i == CMD_KEY_B && at_b_i) state_d = ST_UNL2;
          ST_UNL2: begin
            if (data_i == CMD_SIG && at_a_i)        sig_d   = 1'b1;
            else if (data_i == CMD_PROG)            state_d = ST_PROG;
            else if (data_i == CMD_ERASE && at_a_i) state_d = ST_ERS1;
          end
          ST_ERS1: if (data_i == CMD_KEY_A && at_a_i) state_d = ST_ERS2;
          ST_ERS2: if (data_i == CMD_KEY_B && at_b_i) state_d = ST_ERS3;
          ST_ERS3: begin
            if (data_i == CMD_CHIP && at_a_i) ev_chip_o = 1'b1;
            else if (data_i == CMD_BLOCK)     ev_blk_o  = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sig_q   <= 1'b0;
    end else if (wr_i) begin
      state_q <= state_d;
      sig_q   <= sig_d;
    end
  end

  assign sig_o = sig_q;

  assert_prog_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && wr_i) |=> (state_q == ST_IDLE));

  assert_sig_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_q) |-> $past(state_q == ST_UNL2 && at_a_i));

  assert_erase_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERS3) |-> $past(state_q == ST_ERS2 || state_q == ST_ERS3));
endmodule

// File: rtl/fcs_sig_decode.sv
module fcs_sig_decode
  import fcs_pkg::*;
#(
  parameter int unsigned NBLK     = 8,
  parameter logic [7:0]  MFR_CODE = 8'h3C,
  parameter logic [7:0]  DEV_CODE = 8'hC7,
  localparam int unsigned BW      = $clog2(NBLK)
) (
  input  logic            sig_i,
  input  logic            a0_i,
  input  logic            a1_i,
  input  logic            a6_i,
  input  logic [BW-1:0]   blk_i,
  input  logic [NBLK-1:0] prot_i,
  output logic [1:0]      rd_sel_o,
  output logic [7:0]      sig_byte_o
);
  rd_sel_e sel;

  always_comb begin
    sel        = RS_ARRAY;
    sig_byte_o = 8'h00;
    if (sig_i && !a6_i) begin
      unique case ({a1_i, a0_i})
        2'b00: begin sel = RS_MFR;  sig_byte_o = MFR_CODE; end
        2'b01: begin sel = RS_DEV;  sig_byte_o = DEV_CODE; end
        2'b10: begin sel = RS_PROT; sig_byte_o = {7'd0, prot_i[blk_i]}; end
        default: ;
      endcase
    end
  end

  assign rd_sel_o = sel;

  always_comb begin
    if (!sig_i) assert_array_outside_R3: assert (rd_sel_o == RS_ARRAY);
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int unsigned   AW       = 19,
  parameter int unsigned   NBLK     = 8,
  parameter int unsigned   KW       = 15,
  parameter logic [KW-1:0] KEY_A    = 15'h5555,
  parameter logic [KW-1:0] KEY_B    = 15'h2AAA,
  parameter logic [7:0]    MFR_CODE = 8'h3C,
  parameter logic [7:0]    DEV_CODE = 8'hC7,
  localparam int unsigned  BW       = $clog2(NBLK)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      data_i,
  input  logic            busy_i,
  input  logic            suspended_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic [NBLK-1:0] prot_i,
  output logic [1:0]      rd_sel_o,
  output logic [7:0]      sig_byte_o,
  output logic            prog_req_o,
  output logic [AW-1:0]   prog_addr_o,
  output logic [7:0]      prog_data_o,
  output logic            chip_erase_o,
  output logic            blk_erase_o,
  output logic [BW-1:0]   blk_o,
  output logic            suspend_o,
  output logic            resume_o,
  output logic            reset_o
);
  logic     at_a, at_b, active, wr_idle, sig;
  logic     ev_prog, ev_chip, ev_blk, ev_rst;
  logic     b_rst, b_sus, b_res, b_add;
  op_kind_e kind_q;
  logic     unused_rd_bits;

  assign unused_rd_bits = ^rd_addr_i;

  fcs_addr_match #(.KW(KW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
    .key_bits_i (addr_i[KW-1:0]),
    .at_a_o     (at_a),
    .at_b_o     (at_b)
  );

  fcs_busy_filter u_filter (
    .wr_i     (wr_i),
    .data_i   (data_i),
    .busy_i   (busy_i),
    .susp_i   (suspended_i),
    .kind_i   (kind_q),
    .active_o (active),
    .rst_o    (b_rst),
    .sus_o    (b_sus),
    .res_o    (b_res),
    .add_o    (b_add)
  );

  assign wr_idle = wr_i & ~active;

  fcs_unlock_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_idle),
    .data_i    (data_i),
    .at_a_i    (at_a),
    .at_b_i    (at_b),
    .ev_prog_o (ev_prog),
    .ev_chip_o (ev_chip),
    .ev_blk_o  (ev_blk),
    .ev_rst_o  (ev_rst),
    .sig_o     (sig)
  );

  fcs_sig_decode #(.NBLK(NBLK), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_sig (
    .sig_i      (sig),
    .a0_i       (rd_addr_i[0]),
    .a1_i       (rd_addr_i[1]),
    .a6_i       (rd_addr_i[6]),
    .blk_i      (rd_addr_i[AW-1 -: BW]),
    .prot_i     (prot_i),
    .rd_sel_o   (rd_sel_o),
    .sig_byte_o (sig_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o   <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      chip_erase_o <= 1'b0;
      blk_erase_o  <= 1'b0;
      blk_o        <= '0;
      suspend_o    <= 1'b0;
      resume_o     <= 1'b0;
      reset_o      <= 1'b0;
      kind_q       <= OP_NONE;
    end else begin
      prog_req_o   <= ev_prog;
      chip_erase_o <= ev_chip;
      blk_erase_o  <= ev_blk | b_add;
      suspend_o    <= b_sus;
      resume_o     <= b_res;
      reset_o      <= ev_rst | b_rst;
      if (ev_prog) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
        kind_q      <= OP_PROG;
      end
      if (ev_chip) kind_q <= OP_CHIP;
      if (ev_blk)  kind_q <= OP_BLK;
      if (ev_blk | b_add) blk_o <= addr_i[AW-1 -: BW];
    end
  end

  assert_single_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, chip_erase_o, blk_erase_o, suspend_o, resume_o, reset_o}));

  assert_pulse_after_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o | chip_erase_o | blk_erase_o | suspend_o | resume_o | reset_o)
      |-> $past(wr_i));

  assert_prog_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !suspended_i && kind_q == OP_PROG)
      |=> !(prog_req_o | chip_erase_o | blk_erase_o | suspend_o | resume_o | reset_o));

  assert_suspend_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(busy_i && !suspended_i && kind_q == OP_BLK));

  assert_resume_source_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(suspended_i));

  assert_chip_only_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !suspended_i && kind_q == OP_CHIP)
      |=> !(prog_req_o | chip_erase_o | blk_erase_o | suspend_o | resume_o));
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MFR = 8'h3C;
  localparam logic [7:0] DEV = 8'hC7;

  logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0, busy = 1'b0, susp = 1'b0;
  logic [18:0] addr = '0, rd_addr = '0;
  logic [7:0]  data = '0, prot = 8'hA5;
  logic [1:0]  rd_sel;
  logic [7:0]  sig_byte, prog_data;
  logic [18:0] prog_addr;
  logic [2:0]  blk;
  logic        prog_req, chip_erase, blk_erase, suspend, resume, rst_pulse;

  flash_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .busy_i(busy), .suspended_i(susp), .rd_addr_i(rd_addr), .prot_i(prot),
    .rd_sel_o(rd_sel), .sig_byte_o(sig_byte), .prog_req_o(prog_req),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .chip_erase_o(chip_erase),
    .blk_erase_o(blk_erase), .blk_o(blk), .suspend_o(suspend), .resume_o(resume),
    .reset_o(rst_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: step 0 idle,1..2 unlock,3 prog data,4..6 erase; kind 0 none,1 prog,2 chip,3 blk
  int          m_step, m_kind;
  bit          m_sig;
  bit   [5:0]  m_ev;  // {prog, chip, blk, sus, res, rst}
  logic [18:0] m_pa;
  logic [7:0]  m_pd;
  logic [2:0]  m_blk;
  string       cur_req = "R14";
  int          checks = 0, fails = 0;
  bit          finished = 0;

  task automatic model_write(input logic [18:0] a, input logic [7:0] d);
    bit ka = (a[14:0] == 15'h5555);
    bit kb = (a[14:0] == 15'h2AAA);
    if (susp) begin
      if (d == 8'h30) m_ev[1] = 1;
      else if (d == 8'hF0) m_ev[0] = 1;
    end else if (busy) begin
      if (m_kind == 2 && d == 8'hF0) m_ev[0] = 1;
      if (m_kind == 3) begin
        if (d == 8'hB0) m_ev[2] = 1;
        else if (d == 8'h30) begin m_ev[3] = 1; m_blk = a[18:16]; end
        else if (d == 8'hF0) m_ev[0] = 1;
      end
    end else begin
      m_sig = 0;
      if (m_step == 3) begin
        m_ev[5] = 1; m_pa = a; m_pd = d; m_kind = 1; m_step = 0;
      end else if (d == 8'hF0) begin
        m_ev[0] = 1; m_step = 0;
      end else begin
        case (m_step)
          0: m_step = (d == 8'hAA && ka) ? 1 : 0;
          1: m_step = (d == 8'h55 && kb) ? 2 : 0;
          2: begin
            m_step = 0;
            if (d == 8'h90 && ka) m_sig = 1;
            else if (d == 8'hA0) m_step = 3;
            else if (d == 8'h80 && ka) m_step = 4;
          end
          4: m_step = (d == 8'hAA && ka) ? 5 : 0;
          5: m_step = (d == 8'h55 && kb) ? 6 : 0;
          6: begin
            m_step = 0;
            if (d == 8'h10 && ka) begin m_ev[4] = 1; m_kind = 2; end
            else if (d == 8'h30) begin m_ev[3] = 1; m_blk = a[18:16]; m_kind = 3; end
          end
          default: m_step = 0;
        endcase
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_kind = 0; m_sig = 0; m_ev = '0; m_pa = '0; m_pd = '0; m_blk = '0;
    end else begin
      m_ev = '0;
      if (wr) model_write(addr, data);
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [1:0] es;
    logic [7:0] eb;
    if (!finished) begin
      es = 2'd0; eb = 8'h00;
      if (m_sig && !rd_addr[6]) begin
        case (rd_addr[1:0])
          2'b00: begin es = 2'd1; eb = MFR; end
          2'b01: begin es = 2'd2; eb = DEV; end
          2'b10: begin es = 2'd3; eb = {7'd0, prot[rd_addr[18:16]]}; end
          default: ;
        endcase
      end
      chk("pulses", {26'd0, prog_req, chip_erase, blk_erase, suspend, resume, rst_pulse}, {26'd0, m_ev});
      chk("prog_addr/data", {5'd0, prog_addr, prog_data}, {5'd0, m_pa, m_pd});
      chk("blk", {29'd0, blk}, {29'd0, m_blk});
      chk("read select", {22'd0, rd_sel, sig_byte}, {22'd0, es, eb});
    end
  end

  task automatic wr1(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); #1; wr = 1; addr = a; data = d;
    @(negedge clk); #1; wr = 0;
  endtask

  task automatic wrb(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); #1; wr = 1; addr = a; data = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; wr = 0; end
  endtask

  task automatic unlock();
    wr1(19'h05555, 8'hAA); wr1(19'h02AAA, 8'h55);
  endtask

  task automatic engine(input logic b, input logic s);
    @(negedge clk); #1; busy = b; susp = s;
  endtask

  task automatic set_rd(input logic [18:0] a);
    @(negedge clk); #1; rd_addr = a; idle(1);
  endtask

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cur_req = "R14";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(3);

    cur_req = "R1";  // upper address bits set on both keys
    wr1(19'h7D555, 8'hAA); wr1(19'h4AAAA, 8'h55);
    cur_req = "R3";
    wr1(19'h05555, 8'h90);
    set_rd(19'h00000); set_rd(19'h00001); set_rd(19'h00002);
    set_rd(19'h10002); set_rd(19'h20002); set_rd(19'h00040); set_rd(19'h00003);
    cur_req = "R4";
    wr1(19'h00000, 8'h12);
    set_rd(19'h00001); set_rd(19'h00000);

    cur_req = "R5";
    unlock(); wr1(19'h12345, 8'hA0); wr1(19'h3ABCD, 8'hF0);
    cur_req = "R9";
    engine(1, 0);
    wr1(19'h05555, 8'hF0); wr1(19'h05555, 8'hAA); wr1(19'h00000, 8'hB0); wr1(19'h00000, 8'h30);
    engine(0, 0); idle(2);

    cur_req = "R6";
    unlock(); wr1(19'h05555, 8'h80); unlock(); wr1(19'h05555, 8'h10);
    cur_req = "R10";
    engine(1, 0);
    wr1(19'h00000, 8'hB0); wr1(19'h00000, 8'h30); wr1(19'h11111, 8'hF0);
    engine(0, 0); idle(2);

    cur_req = "R7";
    unlock(); wr1(19'h05555, 8'h80); unlock(); wr1(19'h52345, 8'h30);
    cur_req = "R11";
    engine(1, 0);
    wr1(19'h20000, 8'h30); wr1(19'h00000, 8'h77); wr1(19'h00000, 8'hB0);
    cur_req = "R12";
    engine(1, 1);
    wr1(19'h00000, 8'hB0); wr1(19'h00000, 8'h12); wr1(19'h60000, 8'h30);
    engine(1, 0);
    cur_req = "R11";
    wr1(19'h00000, 8'h55); wr1(19'h00000, 8'hF0);
    engine(0, 1);
    cur_req = "R12";
    wr1(19'h00000, 8'hF0);
    engine(0, 0); idle(2);

    cur_req = "R8";
    wr1(19'h05555, 8'hAA); wr1(19'h02AAA, 8'h56); wr1(19'h02AAA, 8'h55); wr1(19'h05555, 8'h90);
    set_rd(19'h00000);
    wr1(19'h05554, 8'hAA); wr1(19'h02AAA, 8'h55); wr1(19'h05555, 8'h90);
    unlock(); wr1(19'h05555, 8'h80); unlock(); wr1(19'h05555, 8'h20);
    unlock(); wr1(19'h05555, 8'h80); wr1(19'h05555, 8'h55); wr1(19'h05555, 8'h10);
    unlock(); wr1(19'h05555, 8'h80); unlock(); wr1(19'h05554, 8'h10);
    wr1(19'h00000, 8'hB0); wr1(19'h00000, 8'h30);
    unlock(); wr1(19'h05556, 8'h90); set_rd(19'h00001);

    cur_req = "R2";
    wr1(19'h44444, 8'hF0);
    wr1(19'h05555, 8'hAA); wr1(19'h00000, 8'hF0);
    unlock(); wr1(19'h05555, 8'h80); unlock(); wr1(19'h05555, 8'hF0);

    cur_req = "R13";  // back-to-back writes
    wrb(19'h05555, 8'hAA); wrb(19'h02AAA, 8'h55); wrb(19'h05555, 8'hA0);
    wrb(19'h01234, 8'h00); wrb(19'h00000, 8'hF0);
    wrb(19'h05555, 8'hAA); wrb(19'h02AAA, 8'h55); wrb(19'h05555, 8'h90);
    idle(1); set_rd(19'h00001);
    wr1(19'h00000, 8'hF0);
    idle(4);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL %s watchdog: actual hung expected done", cur_req);
      report();
    end
  end
endmodule